// File: doc/BRIEF.md
# Comparator Edge-Event Interrupt Controller

This block is the digital side of a single analog comparator. The comparator result enters as an asynchronous bit. It may be inverted, and it is then brought into the clock domain through a chain of flip-flops. The block compares consecutive synchronized samples to find rising edges, falling edges or both. A qualifying edge sets a sticky event flag. That flag drives a maskable interrupt and, if selected, a fault line. The fault line can instead follow the live synchronized level.

Software reaches the block over a plain 32-bit register bus with separate write and read strobes. Read data is combinational on the address. A read strobe is needed only where a read has a side effect. The mode and analog-setting registers can be locked by a key-guarded write-protection register. A write to the control register can return every register and flag to its reset value. The comparator input selections, the hysteresis code and the bias option are held in registers and are only driven out to the analog macro.

Register offsets (bytes): 0x00 control, 0x04 mode, 0x08 mask-set, 0x0C mask-clear, 0x10 mask readback, 0x14 status, 0x18 analog settings, 0x1C protection, 0x20 protection status.

Top module: `cmp_event_ctrl`

## Requirements
- R1: Status bit 1 shows the synchronized level, which is (comparator input XOR invert bit) delayed by two clock edges. It is 0 after reset, and it follows the input even while the comparator path is disabled.
- R2: The edge-type field, mode bits 2:1, selects the event: 0 counts rising edges of the level, 1 falling edges, 2 either edge, and 3 no edge. The event flag (status bit 0) reads 1 on the third clock edge after the input change.
- R3: Mode bit 3 inverts the comparator input ahead of synchronization. Toggling it therefore flips the level, and edge types act on the inverted signal.
- R4: While the enable bit (mode bit 0) is 0, no edge sets the event flag. Re-enabling with a steady level causes no event.
- R5: The event flag stays set until a bus read of the status register. If an event occurs in the same cycle as that read, the flag stays set.
- R6: Writing 1 in bit 0 of the mask-set register sets the interrupt mask, and writing 1 in bit 0 of the mask-clear register clears it. The mask reads back in bit 0 at 0x10, and the interrupt output equals (event flag AND mask).
- R7: With fault enable (mode bit 5) at 0, the fault output is 0. With it at 1, mode bit 4 selects the event flag (0) or the synchronized level (1).
- R8: A write to the protection register changes its lock bit (bit 0) only when bits 31:8 equal 0x414343. Reads of this register return only the lock bit, with bits 31:8 as 0.
- R9: While locked, writes to the mode and analog registers leave them and their exported fields unchanged, and they set the violation bit (bit 0 at 0x20). A read of 0x20 clears that bit.
- R10: Writing 1 to bit 0 of the control register returns mode, mask, flags, lock, violation, analog settings and synchronizer state to reset values. This write works even while the block is locked.
- R11: Mode bits 10:8 and 14:12 drive the negative and positive input selects. Analog bit 0 drives the bias option and analog bits 2:1 drive the hysteresis code. All of these read back from their registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_async | input | 1 | Raw comparator output, asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on address |
| irq | output | 1 | Interrupt request |
| fault | output | 1 | Fault line |
| neg_sel | output | 3 | Negative input select |
| pos_sel | output | 3 | Positive input select |
| hyst_sel | output | 2 | Hysteresis code |
| bias_fast | output | 1 | Bias option (1 = fast) |

## Verification
The synchronizer latency and the edge flag are probed cycle by cycle after a single rising step. This separates a missing or extra flop from a wrong edge polarity. Directed cases then put an event in the same cycle as a status read, toggle the invert bit so that it alone makes an edge, and toggle the input while the path is disabled. These show whether the flag prefers the set and whether the enable gates the edge detector or only the output. A seeded random phase draws edge type, inversion and input steps, and compares flag and level against a bench function for every edge type. This includes the unused code 3, which must never report an event.

// File: rtl/cmp_event_ctrl.sv
module cmp_event_ctrl #(
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [23:0] LOCK_KEY = 24'h414343
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_async,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              fault,
  output logic [2:0]        neg_sel,
  output logic [2:0]        pos_sel,
  output logic [1:0]        hyst_sel,
  output logic              bias_fast
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_ANA   = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_LSTAT = ADDR_W'('h20);
  localparam int LAST = SYNC_STAGES - 1;

  logic       mode_en, mode_inv, fsel, fen;
  logic [1:0] edge_type;
  logic       mask_q, flag_q, lock_q, viol_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic       lvl, lvl_q, hit, edge_now;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_mode = bus_wr && bus_addr == A_MODE;
  wire wr_mset = bus_wr && bus_addr == A_MSET;
  wire wr_mclr = bus_wr && bus_addr == A_MCLR;
  wire wr_ana  = bus_wr && bus_addr == A_ANA;
  wire wr_lock = bus_wr && bus_addr == A_LOCK;
  wire rd_stat = bus_rd && bus_addr == A_STAT;
  wire rd_lst  = bus_rd && bus_addr == A_LSTAT;
  wire sw_rst  = wr_ctrl && bus_wdata[0];
  wire key_ok  = bus_wdata[31:8] == LOCK_KEY;

  // synchronizer, inversion ahead of the first flop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
    end else if (sw_rst) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_async ^ mode_inv};
      lvl_q  <= sync_q[LAST];
    end
  end

  assign lvl = sync_q[LAST];

  always_comb begin
    case (edge_type)
      2'd0:    hit = lvl & ~lvl_q;
      2'd1:    hit = ~lvl & lvl_q;
      2'd2:    hit = lvl ^ lvl_q;
      default: hit = 1'b0;
    endcase
  end

  assign edge_now = mode_en & hit;

  // mode and analog settings, lockable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en <= 1'b0; edge_type <= 2'd0; mode_inv <= 1'b0;
      fsel <= 1'b0; fen <= 1'b0; neg_sel <= 3'd0; pos_sel <= 3'd0;
      bias_fast <= 1'b0; hyst_sel <= 2'd0;
    end else if (sw_rst) begin
      mode_en <= 1'b0; edge_type <= 2'd0; mode_inv <= 1'b0;
      fsel <= 1'b0; fen <= 1'b0; neg_sel <= 3'd0; pos_sel <= 3'd0;
      bias_fast <= 1'b0; hyst_sel <= 2'd0;
    end else begin
      if (wr_mode && !lock_q) begin
        mode_en   <= bus_wdata[0];
        edge_type <= bus_wdata[2:1];
        mode_inv  <= bus_wdata[3];
        fsel      <= bus_wdata[4];
        fen       <= bus_wdata[5];
        neg_sel   <= bus_wdata[10:8];
        pos_sel   <= bus_wdata[14:12];
      end
      if (wr_ana && !lock_q) begin
        bias_fast <= bus_wdata[0];
        hyst_sel  <= bus_wdata[2:1];
      end
    end
  end

  // event flag, mask, lock and violation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0; mask_q <= 1'b0; lock_q <= 1'b0; viol_q <= 1'b0;
    end else if (sw_rst) begin
      flag_q <= 1'b0; mask_q <= 1'b0; lock_q <= 1'b0; viol_q <= 1'b0;
    end else begin
      if (edge_now)     flag_q <= 1'b1;
      else if (rd_stat) flag_q <= 1'b0;
      if (wr_mclr && bus_wdata[0])      mask_q <= 1'b0;
      else if (wr_mset && bus_wdata[0]) mask_q <= 1'b1;
      if (wr_lock && key_ok) lock_q <= bus_wdata[0];
      if ((wr_mode || wr_ana) && lock_q) viol_q <= 1'b1;
      else if (rd_lst)                   viol_q <= 1'b0;
    end
  end

  assign irq   = flag_q & mask_q;
  assign fault = fen & (fsel ? lvl : flag_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata = {17'd0, pos_sel, 1'b0, neg_sel, 2'd0, fen, fsel,
                            mode_inv, edge_type, mode_en};
      A_MASK:  bus_rdata[0] = mask_q;
      A_STAT:  bus_rdata[1:0] = {lvl, flag_q};
      A_ANA:   bus_rdata[2:0] = {hyst_sel, bias_fast};
      A_LOCK:  bus_rdata[0] = lock_q;
      A_LSTAT: bus_rdata[0] = viol_q;
      default: bus_rdata = '0;
    endcase
  end

  p_hold_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !rd_stat && !sw_rst |=> flag_q);
  p_clear_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !edge_now |=> !flag_q);
  p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en && !flag_q |=> !flag_q);
  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset && bus_wdata[0] |=> mask_q);
  p_lock_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode && lock_q |=> $stable(neg_sel) && $stable(mode_en) && viol_q);
  p_bad_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lock && !key_ok |=> $stable(lock_q));
  p_swrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !mask_q && !flag_q && !mode_en && !lock_q && !irq);

endmodule

// File: tb/tb_cmp_event_ctrl.sv
module tb_cmp_event_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, cmp_async = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, fault, bias_fast;
  logic [2:0] neg_sel, pos_sel;
  logic [1:0] hyst_sel;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  localparam logic [31:0] KEYW = 32'h41434300;

  always #5 clk = ~clk;

  cmp_event_ctrl dut (.clk, .rst_n, .cmp_async, .bus_wr, .bus_rd, .bus_addr,
    .bus_wdata, .bus_rdata, .irq, .fault, .neg_sel, .pos_sel, .hyst_sel, .bias_fast);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] mk_mode(bit en, bit [1:0] et, bit inv,
      bit fs, bit fe, bit [2:0] ng, bit [2:0] ps);
    return {17'd0, ps, 1'b0, ng, 2'd0, fe, fs, inv, et, en};
  endfunction

  function automatic bit exp_hit(bit [1:0] et, bit a, bit b);
    return (et == 0 && !a && b) || (et == 1 && a && !b) || (et == 2 && a != b);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit rawv;
    bit [1:0] et;
    bit iv, nv;
    void'($urandom(32'd2024));
    idle(2); rst_n = 1'b1; idle(1);

    rd(8'h04, d); chk("R10 reset mode", d, 0);
    rd(8'h14, d); chk("R1 reset status", d, 0);
    chk("R6 reset irq", {irq, fault}, 0);

    // R11 exported fields
    wr(8'h04, mk_mode(1, 0, 0, 0, 0, 3'd5, 3'd6));
    wr(8'h18, 32'h5);
    chk("R11 neg/pos", {neg_sel, pos_sel}, {3'd5, 3'd6});
    chk("R11 hyst/bias", {hyst_sel, bias_fast}, {2'd2, 1'b1});
    rd(8'h04, d); chk("R11 mode readback", d, mk_mode(1, 0, 0, 0, 0, 3'd5, 3'd6));

    // R1/R2 latency of level and flag
    @(negedge clk); cmp_async = 1'b1; bus_addr = 8'h14;
    @(negedge clk); #1 chk("R1 level after 1 edge", bus_rdata[1:0], 2'b00);
    @(negedge clk); #1 chk("R1 level after 2 edges", bus_rdata[1:0], 2'b10);
    @(negedge clk); #1 chk("R2 flag after 3 edges", bus_rdata[1:0], 2'b11);

    // R6 mask
    chk("R6 irq masked", irq, 0);
    wr(8'h08, 1); rd(8'h10, d); chk("R6 mask set", d, 1); chk("R6 irq on", irq, 1);
    wr(8'h0C, 1); rd(8'h10, d); chk("R6 mask clr", d, 0); chk("R6 irq off", irq, 0);
    wr(8'h08, 1);

    // R5 read clears
    rd(8'h14, d); chk("R5 read shows flag", d[0], 1);
    chk("R5 irq after clear", irq, 0);
    rd(8'h14, d); chk("R5 flag cleared", d[0], 0);

    // R5 edge in the same cycle as read
    @(negedge clk); cmp_async = 1'b0; idle(4); rd(8'h14, d);
    cmp_async = 1'b1; idle(1);
    rd(8'h14, d); chk("R5 read before set", d[0], 0);
    rd(8'h14, d); chk("R5 set beats clear", d[0], 1);

    // R4 disabled
    wr(8'h04, mk_mode(0, 2, 0, 0, 0, 0, 0));
    @(negedge clk); cmp_async = 1'b0; idle(4);
    rd(8'h14, d); chk("R4 no flag while off", d, 0);
    wr(8'h04, mk_mode(1, 2, 0, 0, 0, 0, 0)); idle(4);
    rd(8'h14, d); chk("R4 no event on enable", d, 0);

    // R3 invert: input 0, inverted level becomes 1 -> rising
    wr(8'h04, mk_mode(1, 0, 1, 0, 0, 0, 0)); idle(4);
    rd(8'h14, d); chk("R3 invert makes rising", d, 3);
    @(negedge clk); cmp_async = 1'b1; idle(4);
    rd(8'h14, d); chk("R3 falling ignored", d, 0);

    // R7 fault
    wr(8'h04, mk_mode(1, 2, 0, 1, 1, 0, 0)); idle(4);
    chk("R7 fault follows level", fault, 1);
    @(negedge clk); cmp_async = 1'b0; idle(3);
    chk("R7 fault level low", fault, 0);
    wr(8'h04, mk_mode(1, 2, 0, 0, 1, 0, 0));
    chk("R7 fault from flag", fault, 1);
    wr(8'h04, mk_mode(1, 2, 0, 0, 0, 0, 0));
    chk("R7 fault off", fault, 0);
    rd(8'h14, d);

    // R8 key
    wr(8'h1C, 32'h41434401); rd(8'h1C, d); chk("R8 bad key", d, 0);
    wr(8'h1C, KEYW | 1); rd(8'h1C, d); chk("R8 good key readback", d, 1);

    // R9 locked writes
    wr(8'h04, mk_mode(1, 1, 0, 0, 0, 3'd1, 3'd2));
    chk("R9 fields unchanged", {neg_sel, pos_sel}, 6'd0);
    rd(8'h04, d); chk("R9 mode unchanged", d, mk_mode(1, 2, 0, 0, 0, 0, 0));
    wr(8'h18, 0); chk("R9 analog unchanged", {hyst_sel, bias_fast}, 3'b101);
    rd(8'h20, d); chk("R9 violation set", d, 1);
    rd(8'h20, d); chk("R9 violation cleared", d, 0);

    // R10 soft reset while locked
    @(negedge clk); cmp_async = 1'b1; idle(4);
    wr(8'h00, 1);
    rd(8'h04, d); chk("R10 mode", d, 0);
    rd(8'h10, d); chk("R10 mask", d, 0);
    rd(8'h1C, d); chk("R10 lock", d, 0);
    rd(8'h18, d); chk("R10 analog", d, 0);
    chk("R10 irq", irq, 0);

    // random phase
    idle(4); rd(8'h14, d); rawv = cmp_async;
    for (int i = 0; i < 60; i++) begin
      et = 2'($urandom % 4); iv = 1'($urandom % 2);
      wr(8'h04, mk_mode(1, et, iv, 0, 0, 0, 0)); idle(4);
      rd(8'h14, d);
      nv = 1'($urandom % 2);
      @(negedge clk); cmp_async = nv; idle(4);
      rd(8'h14, d);
      chk("R2 random flag", d[0], exp_hit(et, rawv ^ iv, nv ^ iv));
      chk("R3 random level", d[1], nv ^ iv);
      rawv = nv;
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule